// File: doc/BRIEF.md
# Chunked Constant-Insert Execution Unit

This unit carries out two 32-bit constant-load instructions on a 64-bit general register file. On each valid instruction it decodes the word and reads the destination register through the file's combinational read port. It then replaces one 16-bit slice ("chunk") of that register with the instruction's 16-bit immediate and sends the merged value back through the write port one clock later. Four such loads, one per chunk, build any 64-bit constant.

The zero-extending form (opcode 0x40) changes only the selected chunk. The sign-extending form (opcode 0x41) also sets every chunk above the selected one to copies of immediate bit 15, so one instruction can load a short negative value. Chunks below the selected one always keep their old contents. A result that is still waiting to be written is forwarded to an instruction that follows at once, so back-to-back loads to the same register build on each other. Register 0 is hardwired to zero. Any other opcode raises a one-cycle illegal flag.

Top module: `cins_unit`

## Requirements
- R1: Instruction fields are opcode in bits 31-24, chunk index n in bits 23-22, immediate in bits 21-6 and destination in bits 5-0. Opcode 0x40 writes the immediate into destination bits 16n+15..16n and leaves every other bit of the destination unchanged.
- R2: Opcode 0x41 writes the immediate into chunk n, sets every bit of chunks n+1 through 3 to immediate bit 15, and leaves chunks below n unchanged.
- R3: Opcode 0x41 with chunk index 3 changes only bits 63-48 and leaves bits 47-0 unchanged.
- R4: For an accepted load, `wb_en` is high for exactly the one cycle after the cycle in which `in_valid` was high. In that cycle `wb_addr` equals the destination field.
- R5: While `in_valid` is high, `rf_rd_addr` equals instruction bits 5-0 in the same cycle.
- R6: A load whose destination is register 0 produces no write-back and no illegal flag.
- R7: A valid instruction whose opcode is neither 0x40 nor 0x41 sets `illegal` high for exactly the following cycle and produces no write-back.
- R8: A load issued in the cycle right after a load to the same register merges into that earlier load's result, not into the stale register-file value.
- R9: After reset, `wb_en` and `illegal` are low.
- R10: With `in_valid` low, no write-back and no illegal flag are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_instr | input | 32 | Instruction word |
| rf_rd_addr | output | 6 | Register-file read address |
| rf_rd_data | input | 64 | Register-file read data, combinational from `rf_rd_addr` |
| wb_en | output | 1 | Register-file write enable |
| wb_addr | output | 6 | Register-file write address |
| wb_data | output | 64 | Register-file write data |
| illegal | output | 1 | Illegal-opcode pulse |

## Verification
A wrong merge shows up in `wb_data` in the cycle after the instruction: a chunk in the wrong place, a sign fill missing or reaching the wrong chunks, or lower chunks overwritten. The write-back stage is the only state in the unit. If it holds a wrong value, a load issued right after it to the same register inherits that value, so a failed forward appears one cycle later in the second load's write data. Faults in write-enable or flag timing appear as a pulse that is missing, doubled or shifted by a cycle on `wb_en` or `illegal`. The bench checks each of these in the exact cycle where it must occur.

// File: rtl/cins_pkg.sv
package cins_pkg;

   // Decoded operation class
   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_UNS  = 2'd1,
      K_SGN  = 2'd2,
      K_BAD  = 2'd3
   } cins_kind_e;

   localparam int unsigned DEF_CHUNK_W  = 16;
   localparam int unsigned DEF_N_CHUNKS = 4;
   localparam int unsigned DEF_RA_W     = 6;
   localparam int unsigned DEF_OP_W     = 8;

endpackage

// File: rtl/cins_decode.sv
module cins_decode
   import cins_pkg::*;
#(
   parameter int unsigned OP_W    = 8,
   parameter int unsigned IDX_W   = 2,
   parameter int unsigned CHUNK_W = 16,
   parameter int unsigned RA_W    = 6,
   parameter logic [OP_W-1:0] OPC_UNS = 8'h40,
   parameter logic [OP_W-1:0] OPC_SGN = 8'h41,
   localparam int unsigned INSTR_W = OP_W + IDX_W + CHUNK_W + RA_W
) (
   input  logic               valid,
   input  logic [INSTR_W-1:0] instr,
   output cins_kind_e         kind,
   output logic [IDX_W-1:0]   idx,
   output logic [CHUNK_W-1:0] imm,
   output logic [RA_W-1:0]    dst
);
   localparam int unsigned IMM_LO = RA_W;
   localparam int unsigned IDX_LO = RA_W + CHUNK_W;
   localparam int unsigned OP_LO  = RA_W + CHUNK_W + IDX_W;

   logic [OP_W-1:0] opcode;

   assign dst    = instr[0 +: RA_W];
   assign imm    = instr[IMM_LO +: CHUNK_W];
   assign idx    = instr[IDX_LO +: IDX_W];
   assign opcode = instr[OP_LO +: OP_W];

   always_comb begin
      if (!valid)                 kind = K_NONE;
      else if (opcode == OPC_UNS) kind = K_UNS;
      else if (opcode == OPC_SGN) kind = K_SGN;
      else                        kind = K_BAD;
   end
endmodule

// File: rtl/cins_operand.sv
module cins_operand #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned RA_W     = 6,
   parameter bit          ZERO_REG = 1'b1
) (
   input  logic [RA_W-1:0]   rd_addr,
   input  logic [DATA_W-1:0] rf_data,
   input  logic              pend_en,
   input  logic [RA_W-1:0]   pend_addr,
   input  logic [DATA_W-1:0] pend_data,
   output logic [DATA_W-1:0] oper
);
   logic              hit;
   logic [DATA_W-1:0] fwd;

   // The pending write lands at the coming edge; the file still shows the old value.
   assign hit = pend_en && (pend_addr == rd_addr);
   assign fwd = hit ? pend_data : rf_data;

   generate
      if (ZERO_REG) begin : g_zero_hard
         assign oper = (rd_addr == '0) ? '0 : fwd;
      end else begin : g_zero_soft
         assign oper = fwd;
      end
   endgenerate
endmodule

// File: rtl/cins_merge.sv
module cins_merge #(
   parameter int unsigned CHUNK_W  = 16,
   parameter int unsigned N_CHUNKS = 4,
   localparam int unsigned IDX_W   = $clog2(N_CHUNKS),
   localparam int unsigned DATA_W  = CHUNK_W * N_CHUNKS
) (
   input  logic [DATA_W-1:0]  old_val,
   input  logic [IDX_W-1:0]   idx,
   input  logic [CHUNK_W-1:0] imm,
   input  logic               sext,
   output logic [DATA_W-1:0]  new_val
);
   logic [CHUNK_W-1:0] fill;
   assign fill = {CHUNK_W{imm[CHUNK_W-1]}};

   for (genvar k = 0; k < N_CHUNKS; k++) begin : g_chunk
      logic sel, above;
      assign sel   = (idx == IDX_W'(k));
      assign above = (IDX_W'(k) > idx);
      always_comb begin
         if (sel)
            new_val[k*CHUNK_W +: CHUNK_W] = imm;
         else if (above && sext)
            new_val[k*CHUNK_W +: CHUNK_W] = fill;
         else
            new_val[k*CHUNK_W +: CHUNK_W] = old_val[k*CHUNK_W +: CHUNK_W];
      end
   end
endmodule

// File: rtl/cins_unit.sv
module cins_unit
   import cins_pkg::*;
#(
   parameter int unsigned CHUNK_W  = DEF_CHUNK_W,
   parameter int unsigned N_CHUNKS = DEF_N_CHUNKS,
   parameter int unsigned RA_W     = DEF_RA_W,
   parameter int unsigned OP_W     = DEF_OP_W,
   parameter logic [OP_W-1:0] OPC_UNS = 8'h40,
   parameter logic [OP_W-1:0] OPC_SGN = 8'h41,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = $clog2(N_CHUNKS),
   localparam int unsigned DATA_W  = CHUNK_W * N_CHUNKS,
   localparam int unsigned INSTR_W = OP_W + IDX_W + CHUNK_W + RA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] in_instr,
   output logic [RA_W-1:0]    rf_rd_addr,
   input  logic [DATA_W-1:0]  rf_rd_data,
   output logic               wb_en,
   output logic [RA_W-1:0]    wb_addr,
   output logic [DATA_W-1:0]  wb_data,
   output logic               illegal
);
   // Elaboration checks
   if (N_CHUNKS < 2 || (1 << IDX_W) != N_CHUNKS) begin : g_bad_chunks
      $error("cins_unit: N_CHUNKS must be a power of two, at least 2");
   end
   if (OPC_UNS == OPC_SGN) begin : g_bad_opc
      $error("cins_unit: the two opcodes must differ");
   end
   if (CHUNK_W < 2) begin : g_bad_width
      $error("cins_unit: CHUNK_W too small");
   end

   cins_kind_e         kind;
   logic [IDX_W-1:0]   idx;
   logic [CHUNK_W-1:0] imm;
   logic [RA_W-1:0]    dst;
   logic [DATA_W-1:0]  oper;
   logic [DATA_W-1:0]  merged;
   logic               accept;
   logic               dst_ok;

   cins_decode #(
      .OP_W(OP_W), .IDX_W(IDX_W), .CHUNK_W(CHUNK_W), .RA_W(RA_W),
      .OPC_UNS(OPC_UNS), .OPC_SGN(OPC_SGN)
   ) u_dec (
      .valid(in_valid), .instr(in_instr),
      .kind(kind), .idx(idx), .imm(imm), .dst(dst)
   );

   assign rf_rd_addr = dst;

   cins_operand #(
      .DATA_W(DATA_W), .RA_W(RA_W), .ZERO_REG(ZERO_REG)
   ) u_opnd (
      .rd_addr(dst), .rf_data(rf_rd_data),
      .pend_en(wb_en), .pend_addr(wb_addr), .pend_data(wb_data),
      .oper(oper)
   );

   cins_merge #(
      .CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS)
   ) u_mrg (
      .old_val(oper), .idx(idx), .imm(imm),
      .sext(kind == K_SGN), .new_val(merged)
   );

   generate
      if (ZERO_REG) begin : g_dst_filter
         assign dst_ok = (dst != '0);
      end else begin : g_dst_any
         assign dst_ok = 1'b1;
      end
   endgenerate

   assign accept = ((kind == K_UNS) || (kind == K_SGN)) && dst_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en   <= 1'b0;
         wb_addr <= '0;
         wb_data <= '0;
         illegal <= 1'b0;
      end else begin
         wb_en   <= accept;
         illegal <= (kind == K_BAD);
         if (accept) begin
            wb_addr <= dst;
            wb_data <= merged;
         end
      end
   end
endmodule

// File: rtl/cins_unit_chk.sv
module cins_unit_chk #(
   parameter int unsigned CHUNK_W  = 16,
   parameter int unsigned N_CHUNKS = 4,
   parameter int unsigned RA_W     = 6,
   parameter int unsigned OP_W     = 8,
   parameter logic [OP_W-1:0] OPC_UNS = 8'h40,
   parameter logic [OP_W-1:0] OPC_SGN = 8'h41,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = $clog2(N_CHUNKS),
   localparam int unsigned DATA_W  = CHUNK_W * N_CHUNKS,
   localparam int unsigned INSTR_W = OP_W + IDX_W + CHUNK_W + RA_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [INSTR_W-1:0] in_instr,
   input logic               wb_en,
   input logic [RA_W-1:0]    wb_addr,
   input logic [DATA_W-1:0]  wb_data,
   input logic               illegal
);
   logic               v_q;
   logic [INSTR_W-1:0] i_q;
   logic [OP_W-1:0]    op_q;
   logic [IDX_W-1:0]   idx_q;
   logic [CHUNK_W-1:0] imm_q;
   logic [RA_W-1:0]    dst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         i_q <= '0;
      end else begin
         v_q <= in_valid;
         i_q <= in_instr;
      end
   end

   assign dst_q = i_q[0 +: RA_W];
   assign imm_q = i_q[RA_W +: CHUNK_W];
   assign idx_q = i_q[RA_W + CHUNK_W +: IDX_W];
   assign op_q  = i_q[RA_W + CHUNK_W + IDX_W +: OP_W];

   p_wb_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> v_q);
   p_wb_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_addr == dst_q));
   p_no_reg0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (!ZERO_REG || wb_addr != '0));
   p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !wb_en);
   p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (v_q && op_q != OPC_UNS && op_q != OPC_SGN));
   p_imm_placed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_data[idx_q*CHUNK_W +: CHUNK_W] == imm_q));
   p_top_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && op_q == OPC_SGN) |-> (wb_data[DATA_W-1] == imm_q[CHUNK_W-1]));
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!wb_en && !illegal));
endmodule

bind cins_unit cins_unit_chk #(
   .CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS), .RA_W(RA_W), .OP_W(OP_W),
   .OPC_UNS(OPC_UNS), .OPC_SGN(OPC_SGN), .ZERO_REG(ZERO_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
   .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .illegal(illegal)
);

// File: tb/sim_cins_unit.sv
`timescale 1ns/1ps
module sim_cins_unit;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic [5:0]  rf_rd_addr;
   logic [63:0] rf_rd_data;
   logic        wb_en;
   logic [5:0]  wb_addr;
   logic [63:0] wb_data;
   logic        illegal;

   int n_chk = 0;
   int n_bad = 0;

   // Register file model plus preload port
   logic [63:0] rf [64];
   logic [63:0] mdl [64];
   logic        pl_en = 1'b0;
   logic [5:0]  pl_addr = '0;
   logic [63:0] pl_data = '0;

   always #(PERIOD/2) clk = ~clk;

   assign rf_rd_data = rf[rf_rd_addr];

   always @(posedge clk) begin
      if (pl_en) rf[pl_addr] <= pl_data;
      else if (wb_en) rf[wb_addr] <= wb_data;
   end

   cins_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .illegal(illegal)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [7:0] op, input logic [1:0] n,
                                      input logic [15:0] imm, input logic [5:0] d);
      return {op, n, imm, d};
   endfunction

   // Expected merge, written from R1/R2/R3
   function automatic logic [63:0] ref_val(input logic [63:0] old, input logic [31:0] ins);
      logic [63:0] r = old;
      int n = int'(ins[23:22]);
      logic [15:0] imm = ins[21:6];
      for (int k = 0; k < 4; k++) begin
         if (k == n) r[k*16 +: 16] = imm;
         else if (k > n && ins[31:24] == 8'h41) r[k*16 +: 16] = {16{imm[15]}};
      end
      return r;
   endfunction

   task automatic preload(input logic [5:0] a, input logic [63:0] v);
      @(negedge clk);
      pl_en = 1'b1; pl_addr = a; pl_data = v;
      @(negedge clk);
      pl_en = 1'b0;
      mdl[a] = v;
   endtask

   // Checks outputs for instruction ins, in the cycle after it was valid
   task automatic check_out(input logic [31:0] ins, input string tag);
      logic [7:0] op = ins[31:24];
      logic [5:0] d = ins[5:0];
      bit is_ld = (op == 8'h40 || op == 8'h41);
      bit exp_wr = is_ld && (d != 0);
      logic [63:0] ev = ref_val(mdl[d], ins);
      chk(wb_en == exp_wr, {tag, " R4 wb_en"}, 64'(wb_en), 64'(exp_wr));
      chk(illegal == !is_ld, {tag, " R7 illegal"}, 64'(illegal), 64'(!is_ld));
      if (exp_wr) begin
         chk(wb_addr == d, {tag, " R4 wb_addr"}, 64'(wb_addr), 64'(d));
         chk(wb_data == ev, {tag, " data"}, wb_data, ev);
         mdl[d] = ev;
      end
   endtask

   task automatic issue(input logic [31:0] ins, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_instr = ins;
      #1;
      chk(rf_rd_addr == ins[5:0], {tag, " R5 rd_addr"}, 64'(rf_rd_addr), 64'(ins[5:0]));
      @(negedge clk);
      in_valid = 1'b0;
      check_out(ins, tag);
      @(negedge clk);
      chk(!wb_en && !illegal, {tag, " R4 single pulse"}, 64'({wb_en, illegal}), 64'd0);
   endtask

   task automatic t_reset();
      chk(!wb_en && !illegal, "R9 reset outputs", 64'({wb_en, illegal}), 64'd0);
   endtask

   task automatic t_unsigned();
      preload(6'd5, 64'h1111_2222_3333_4444);
      issue(mk(8'h40, 2'd1, 16'hABCD, 6'd5), "R1 uns n1");
      chk(mdl[5] == 64'h1111_2222_ABCD_4444, "R1 literal", mdl[5], 64'h1111_2222_ABCD_4444);
      issue(mk(8'h40, 2'd0, 16'hFFFF, 6'd5), "R1 uns n0");
      issue(mk(8'h40, 2'd3, 16'h8000, 6'd5), "R1 uns n3");
   endtask

   task automatic t_signed();
      preload(6'd9, 64'h0123_4567_89AB_CDEF);
      issue(mk(8'h41, 2'd1, 16'h8001, 6'd9), "R2 sgn neg n1");
      chk(mdl[9] == 64'hFFFF_FFFF_8001_CDEF, "R2 literal", mdl[9], 64'hFFFF_FFFF_8001_CDEF);
      issue(mk(8'h41, 2'd0, 16'h7FFF, 6'd9), "R2 sgn pos n0");
      issue(mk(8'h41, 2'd2, 16'hC000, 6'd9), "R2 sgn neg n2");
   endtask

   task automatic t_signed_top();
      preload(6'd12, 64'h5555_6666_7777_8888);
      issue(mk(8'h41, 2'd3, 16'h8000, 6'd12), "R3 sgn n3");
      chk(mdl[12] == 64'h8000_6666_7777_8888, "R3 literal", mdl[12], 64'h8000_6666_7777_8888);
   endtask

   task automatic t_zero_dst();
      issue(mk(8'h41, 2'd0, 16'h8000, 6'd0), "R6 reg0");
   endtask

   task automatic t_illegal();
      preload(6'd20, 64'hDEAD_BEEF_0000_1111);
      issue(mk(8'h42, 2'd1, 16'h1234, 6'd20), "R7 bad op");
      issue(mk(8'h00, 2'd0, 16'h0000, 6'd20), "R7 zero op");
      // Register still holds its value: a no-op insert reads it back
      issue(mk(8'h40, 2'd1, 16'h0000, 6'd20), "R7 reg untouched");
      chk(mdl[20] == 64'hDEAD_BEEF_0000_1111, "R7 literal", mdl[20], 64'hDEAD_BEEF_0000_1111);
   endtask

   task automatic t_back_to_back();
      logic [31:0] a, b, c;
      preload(6'd7, 64'h0);
      a = mk(8'h40, 2'd0, 16'h1234, 6'd7);
      b = mk(8'h40, 2'd1, 16'h5678, 6'd7);
      c = mk(8'h41, 2'd2, 16'h9ABC, 6'd7);
      @(negedge clk);
      in_valid = 1'b1; in_instr = a;
      @(negedge clk);
      in_instr = b;
      check_out(a, "R8 b2b first");
      @(negedge clk);
      in_instr = c;
      check_out(b, "R8 b2b second");
      @(negedge clk);
      in_valid = 1'b0;
      check_out(c, "R8 b2b third");
      chk(mdl[7] == 64'hFFFF_9ABC_5678_1234, "R8 literal", mdl[7], 64'hFFFF_9ABC_5678_1234);
      @(negedge clk);
   endtask

   task automatic t_idle();
      in_instr = mk(8'h40, 2'd0, 16'h1111, 6'd3);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!wb_en && !illegal, "R10 idle", 64'({wb_en, illegal}), 64'd0);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         rf[i] = '0;
         mdl[i] = '0;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unsigned();
      t_signed();
      t_signed_top();
      t_zero_dst();
      t_illegal();
      t_back_to_back();
      t_idle();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule